// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind the bus engine of a two-wire serial memory. It gathers the data bytes of one write transaction into a 64-byte staging buffer. It then copies them into the storage array during a fixed-length commit window. The write transaction opens with a word-address load, which fixes the page (upper address bits) and the starting byte offset (lower six bits). Each received byte goes into the buffer at the current offset. The offset then advances and wraps inside the page, and the page bits never change.

A stop strobe that follows at least one received byte starts the commit, unless write protection is asserted. During the commit the block raises `busy_o` for a parameterized number of clock cycles. The bus engine uses that flag to withhold acknowledges, so a host can poll for completion. In the first cycles of the window, the buffered bytes are written to the array in ascending offset order. Only offsets that were actually received are written. The address pointer persists between transactions and serves current-address reads.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy_o` is 0, `arr_we_o` is 0 and `ptr_o` is 0.
- R2: An accepted address load sets `ptr_o` to `addr_i`. Each accepted byte adds one to `ptr_o[5:0]` modulo 64 and leaves `ptr_o[14:6]` unchanged. For example, from offset 63 of page 0x1FF the pointer goes to 0x7FC0.
- R3: Each received byte is written at the array address {page bits, offset it was received at}. When more than 64 bytes arrive, each offset is written once, carrying the last byte received there.
- R4: Only received offsets are written. A one-byte transaction produces exactly one array write.
- R5: A stop with no byte received since the last address load or the last commit starts no busy window and produces no array write.
- R6: An accepted stop after at least one byte, with `wp_i` low, raises `busy_o` from the next cycle. `busy_o` stays high for exactly COMMIT_CYCLES cycles, or PAGE_BYTES cycles if that is larger.
- R7: Every array write happens while `busy_o` is high, and within one commit the offsets are written in strictly ascending order.
- R8: While `busy_o` is high, address loads, bytes and stops are ignored. The pointer does not move, the window is not restarted or lengthened, and no extra write appears.
- R9: If `wp_i` is high when a stop is accepted, no busy window starts and nothing is written. The received bytes are discarded, so a later stop with `wp_i` low writes nothing.
- R10: After a commit, `ptr_o` holds the address of the last received byte plus one, wrapped within its page.
- R11: An address load discards bytes received in an unfinished transaction, so only bytes received after the last load are committed.
- R12: Input priority within one cycle is address load, then byte, then stop; a lower-priority strobe in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write protect; high blocks the commit |
| addr_load_i | input | 1 | Load `addr_i` as the start address of a write transaction |
| addr_i | input | ADDR_W | Word address to load |
| byte_vld_i | input | 1 | One data byte received this cycle |
| byte_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Valid stop condition seen on the bus |
| busy_o | output | 1 | Commit in progress; the bus engine withholds acknowledges |
| ptr_o | output | ADDR_W | Persistent word address pointer |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The bench keeps the default 15-bit address and 64-byte page, so the last page (0x1FF) and its offset wrap are reached directly. It sets COMMIT_CYCLES to 80 in place of a multi-millisecond count. That value keeps each busy window short enough to run many commits. It also stays above the 64-cycle scan, so the quiet tail of the window, during which strobes must be ignored, is exercised as well. With these values, 70-byte overflow, single-byte partial commits, protected transactions and abandoned transactions all fit within a few thousand cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_SCAN = 2'd1,
    CM_TAIL = 2'd2
  } cm_state_e;

  function automatic int max_i(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgw_addr_ptr.sv
module pgw_addr_ptr #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
    end else if (step_i) begin
      off_q  <= off_q + 1'b1;  // wraps inside the page
    end
  end

  assign ptr_o = {page_q, off_q};

  p_page_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> (page_q == $past(page_q)) && (off_q == $past(off_q) + 1'b1));

  p_ptr_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ptr_o));

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  wr_i,
  input  logic [OFF_W-1:0]      wr_off_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [OFF_W-1:0]      rd_off_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [PAGE_BYTES-1:0] mask_o
);
  logic [DATA_W-1:0] lane_data [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_i && (wr_off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (hit) byte_q <= wr_data_i;
        if (clear_i)  vld_q <= 1'b0;
        else if (hit) vld_q <= 1'b1;
      end
    end

    assign lane_data[g] = byte_q;
    assign mask_o[g]    = vld_q;
  end

  assign rd_data_o = lane_data[rd_off_i];

  p_clear_empties_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mask_o == '0));

  p_byte_marked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clear_i |=> mask_o[$past(wr_off_i)]);

endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES    = 64,
  parameter int COMMIT_CYCLES = 250000,
  parameter int OFF_W         = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [PAGE_BYTES-1:0] mask_i,
  output logic                  busy_o,
  output logic                  we_o,
  output logic [OFF_W-1:0]      off_o,
  output logic                  done_o
);
  // window never shorter than the scan of all offsets
  localparam int HOLD  = max_i(COMMIT_CYCLES, PAGE_BYTES);
  localparam int CNT_W = $clog2(HOLD + 1);

  cm_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFF_W-1:0]  idx_q;
  logic              last_idx;
  logic              cnt_zero;

  assign last_idx = (idx_q == OFF_W'(PAGE_BYTES - 1));
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CM_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        CM_IDLE: begin
          if (start_i) begin
            state_q <= CM_SCAN;
            cnt_q   <= CNT_W'(HOLD - 1);
            idx_q   <= '0;
          end
        end
        CM_SCAN: begin
          cnt_q <= cnt_q - 1'b1;
          idx_q <= idx_q + 1'b1;
          if (cnt_zero)      state_q <= CM_IDLE;
          else if (last_idx) state_q <= CM_TAIL;
        end
        CM_TAIL: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_zero) state_q <= CM_IDLE;
        end
        default: state_q <= CM_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != CM_IDLE);
  assign we_o   = (state_q == CM_SCAN) && mask_i[idx_q];
  assign off_o  = idx_q;
  assign done_o = busy_o && cnt_zero;

  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  p_busy_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  p_done_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W        = 15,
  parameter int PAGE_BYTES    = 64,
  parameter int DATA_W        = 8,
  parameter int COMMIT_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic                  busy;
  logic                  acc_load, acc_byte, acc_stop;
  logic                  has_data, go, drop, done, clr;
  logic [PAGE_BYTES-1:0] mask;
  logic [ADDR_W-1:0]     ptr;
  logic [OFF_W-1:0]      scan_off;
  logic [DATA_W-1:0]     rd_data;
  logic                  scan_we;

  // priority: load > byte > stop; all refused while committing
  assign acc_load = addr_load_i && !busy;
  assign acc_byte = byte_vld_i && !addr_load_i && !busy;
  assign acc_stop = stop_i && !byte_vld_i && !addr_load_i && !busy;

  assign has_data = |mask;
  assign go       = acc_stop && has_data && !wp_i;
  assign drop     = acc_stop && wp_i;
  assign clr      = acc_load || drop || done;

  pgw_addr_ptr #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc_load),
    .addr_i (addr_i),
    .step_i (acc_byte),
    .busy_i (busy),
    .ptr_o  (ptr)
  );

  pgw_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .OFF_W      (OFF_W)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr),
    .wr_i      (acc_byte),
    .wr_off_i  (ptr[OFF_W-1:0]),
    .wr_data_i (byte_i),
    .rd_off_i  (scan_off),
    .rd_data_o (rd_data),
    .mask_o    (mask)
  );

  pgw_commit_seq #(
    .PAGE_BYTES    (PAGE_BYTES),
    .COMMIT_CYCLES (COMMIT_CYCLES),
    .OFF_W         (OFF_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go),
    .mask_i  (mask),
    .busy_o  (busy),
    .we_o    (scan_we),
    .off_o   (scan_off),
    .done_o  (done)
  );

  assign busy_o     = busy;
  assign ptr_o      = ptr;
  assign arr_we_o   = scan_we;
  assign arr_addr_o = {ptr[ADDR_W-1:OFF_W], scan_off};
  assign arr_data_o = rd_data;

  p_empty_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stop && !has_data |=> !busy_o);

  p_mask_empty_after_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (mask == '0));

  p_wp_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stop && wp_i |=> !busy_o && (mask == '0));

  p_load_priority_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_i && !busy_o |=> ptr_o == $past(addr_i));

endmodule

// File: tb/sim_page_write_buffer.sv
`timescale 1ns/1ps
module sim_page_write_buffer;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int PB = 64;
  localparam int CC = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b0;
  logic          ld = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          bv = 1'b0;
  logic [DW-1:0] bd = '0;
  logic          stp = 1'b0;
  logic          busy;
  logic [AW-1:0] ptr;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  always #2 clk = ~clk;

  page_write_buffer #(
    .ADDR_W(AW), .PAGE_BYTES(PB), .DATA_W(DW), .COMMIT_CYCLES(CC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp),
    .addr_load_i(ld), .addr_i(ld_addr),
    .byte_vld_i(bv), .byte_i(bd), .stop_i(stp),
    .busy_o(busy), .ptr_o(ptr),
    .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [int];
  logic [7:0] got_mem [int];
  int wr_cnt = 0;
  int busy_cyc = 0;
  int mon_err = 0;
  int last_off = -1;

  // array-side monitor
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    else last_off = -1;
    if (we) begin
      wr_cnt++;
      got_mem[int'(waddr)] = wdata;
      if (!busy) mon_err++;
      if (int'(waddr[5:0]) <= last_off) mon_err++;
      last_off = int'(waddr[5:0]);
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic drv_load(int a);
    ld = 1'b1; ld_addr = AW'(a);
    cyc();
    ld = 1'b0;
  endtask

  task automatic drv_byte(int d);
    bv = 1'b1; bd = DW'(d);
    cyc();
    bv = 1'b0;
  endtask

  task automatic drv_stop();
    stp = 1'b1;
    cyc();
    stp = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) cyc();
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(we == 1'b0, "R1", "write enable after reset", int'(we), 0);
    chk(ptr == '0, "R1", "pointer after reset", int'(ptr), 0);
  endtask

  task automatic t_single();
    int w0, b0;
    w0 = wr_cnt;
    drv_load(16'h0105);
    chk(ptr == 15'h0105, "R2", "pointer after load", int'(ptr), 'h0105);
    drv_byte(8'h5A);
    exp_mem[16'h0105] = 8'h5A;
    b0 = busy_cyc;
    drv_stop();
    chk(busy == 1'b1, "R6", "busy the cycle after stop", int'(busy), 1);
    wait_idle();
    chk(busy_cyc - b0 == CC, "R6", "busy window length", busy_cyc - b0, CC);
    chk(wr_cnt - w0 == 1, "R4", "writes for one byte", wr_cnt - w0, 1);
    chk(ptr == 15'h0106, "R10", "pointer after commit", int'(ptr), 'h0106);
  endtask

  task automatic t_wrap();
    int w0;
    w0 = wr_cnt;
    drv_load(16'h7FFE);
    for (int i = 0; i < 5; i++) begin
      drv_byte(8'h30 + i);
      exp_mem[16'h7FC0 | ((62 + i) & 63)] = 8'(8'h30 + i);
      if (i == 1)
        chk(ptr == 15'h7FC0, "R2", "offset wrap keeps page", int'(ptr), 'h7FC0);
    end
    drv_stop();
    wait_idle();
    chk(wr_cnt - w0 == 5, "R3", "writes after wrap", wr_cnt - w0, 5);
    chk(ptr == 15'h7FC3, "R10", "pointer after wrapped commit", int'(ptr), 'h7FC3);
  endtask

  task automatic t_overflow();
    int w0;
    w0 = wr_cnt;
    drv_load(16'h004A);
    for (int i = 0; i < 70; i++) begin
      drv_byte(i + 1);
      exp_mem[16'h0040 | ((10 + i) & 63)] = 8'(i + 1);
    end
    chk(ptr == 15'h0050, "R2", "pointer after 70 bytes", int'(ptr), 'h0050);
    drv_stop();
    wait_idle();
    chk(wr_cnt - w0 == PB, "R3", "one write per offset on overflow", wr_cnt - w0, PB);
  endtask

  task automatic t_empty_stop();
    int w0;
    w0 = wr_cnt;
    drv_load(16'h0800);
    drv_stop();
    chk(busy == 1'b0, "R5", "stop without bytes stays idle", int'(busy), 0);
    cyc();
    chk(wr_cnt == w0, "R5", "no write for empty stop", wr_cnt - w0, 0);
  endtask

  task automatic t_busy_ignore();
    int w0, b0;
    w0 = wr_cnt;
    drv_load(16'h0200);
    drv_byte(8'hA5);
    drv_byte(8'hA6);
    exp_mem[16'h0200] = 8'hA5;
    exp_mem[16'h0201] = 8'hA6;
    b0 = busy_cyc;
    drv_stop();
    cyc();
    drv_load(16'h3000);
    drv_byte(8'h77);
    drv_stop();
    chk(ptr == 15'h0202, "R8", "pointer frozen while busy", int'(ptr), 'h0202);
    for (int i = 0; i < CC - 10; i++) cyc();
    drv_byte(8'h78);
    drv_stop();
    wait_idle();
    chk(busy_cyc - b0 == CC, "R8", "window not lengthened", busy_cyc - b0, CC);
    chk(wr_cnt - w0 == 2, "R8", "no extra writes from busy strobes", wr_cnt - w0, 2);
    chk(ptr == 15'h0202, "R10", "pointer after commit", int'(ptr), 'h0202);
    drv_stop();
    chk(busy == 1'b0, "R5", "stop after commit stays idle", int'(busy), 0);
  endtask

  task automatic t_protect();
    int w0;
    w0 = wr_cnt;
    wp = 1'b1;
    drv_load(16'h0500);
    for (int i = 0; i < 3; i++) drv_byte(8'hC0 + i);
    drv_stop();
    chk(busy == 1'b0, "R9", "no busy under protection", int'(busy), 0);
    for (int i = 0; i < 4; i++) cyc();
    chk(wr_cnt == w0, "R9", "no write under protection", wr_cnt - w0, 0);
    chk(ptr == 15'h0503, "R9", "pointer still advanced", int'(ptr), 'h0503);
    wp = 1'b0;
    drv_stop();
    chk(busy == 1'b0, "R9", "discarded bytes not committed later", int'(busy), 0);
    cyc();
    chk(wr_cnt == w0, "R9", "no write after unprotect", wr_cnt - w0, 0);
  endtask

  task automatic t_abandon();
    int w0;
    w0 = wr_cnt;
    drv_load(16'h0600);
    drv_byte(8'h11);
    drv_byte(8'h12);
    drv_load(16'h0700);
    drv_byte(8'h21);
    exp_mem[16'h0700] = 8'h21;
    drv_stop();
    wait_idle();
    chk(wr_cnt - w0 == 1, "R11", "only last transaction written", wr_cnt - w0, 1);
    chk(!got_mem.exists(16'h0600), "R11", "abandoned byte absent", 0, 0);
  endtask

  task automatic t_priority();
    int w0;
    w0 = wr_cnt;
    drv_load(16'h0900);
    ld = 1'b1; ld_addr = 15'h0A10; bv = 1'b1; bd = 8'hEE;
    cyc();
    ld = 1'b0; bv = 1'b0;
    chk(ptr == 15'h0A10, "R12", "load beats byte", int'(ptr), 'h0A10);
    bv = 1'b1; bd = 8'h44; stp = 1'b1;
    cyc();
    bv = 1'b0; stp = 1'b0;
    exp_mem[16'h0A10] = 8'h44;
    chk(busy == 1'b0, "R12", "stop ignored beside byte", int'(busy), 0);
    chk(ptr == 15'h0A11, "R12", "byte beats stop", int'(ptr), 'h0A11);
    drv_stop();
    wait_idle();
    chk(wr_cnt - w0 == 1, "R12", "writes after priority test", wr_cnt - w0, 1);
  endtask

  task automatic t_compare();
    int bad;
    bad = 0;
    foreach (exp_mem[a])
      if (!got_mem.exists(a) || got_mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, "R3", "array contents mismatches", bad, 0);
    chk(got_mem.num() == exp_mem.num(), "R4", "written address count", got_mem.num(), exp_mem.num());
    chk(mon_err == 0, "R7", "writes outside busy or out of order", mon_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_single();
    t_wrap();
    t_overflow();
    t_empty_stop();
    t_busy_ignore();
    t_protect();
    t_abandon();
    t_priority();
    t_compare();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule